// File: doc/BRIEF.md
# Stub Vector Serial Tap

This block is a test readout path for coincidence logic. On any bunch crossing where the stub-present flag is high and the tap is free, it copies the 127-bit stub vector into a data shift register in one cycle. It then sends the vector out on one serial line, one bit per crossing.

A second register of the same length, the shadow register, runs in step with the data register. It is filled with ones at capture and shifts in zeros. Its lowest bit marks each serial bit as valid, so the tap stays busy until the last bit of a frame has been presented. A capture request that arrives while a frame is still in flight is dropped and counted in a saturating counter. A configuration enable bit freezes every operation of both registers and the counter.

The serial output is a stream with a valid qualifier and no ready. The consumer must accept each bit in the cycle in which `ser_valid` is high, because the tap cannot be held back. The only way to pause a frame is to clear `en`, which suspends the frame without losing its bits.

Top module: `stub_serial_tap`

## Requirements
- R1: After a synchronous reset, `ser_valid` and `ser_data` are low and `ovf_count` is zero.
- R2: A clock edge with `en` high, `stub_any` high and no frame in flight captures `stub_vec`. `ser_valid` is high in the cycle after that edge.
- R3: While `stub_any` is low no capture happens, whatever `stub_vec` holds. An idle tap keeps `ser_valid` low.
- R4: A captured frame presents exactly 127 valid cycles. The k-th valid cycle carries `stub_vec[k]`, so bit 0 (the lowest strip) goes first.
- R5: `ser_data` is low in every cycle in which `ser_valid` is low.
- R6: A request made while bits remain beyond the one now presented is dropped. The frame in flight is left intact, and `ovf_count` rises by one for each dropped request.
- R7: `ovf_count` is 8 bits wide and saturates at 255.
- R8: While `en` is low, `ser_valid` is low and neither shift register nor `ovf_count` changes. A frame resumes with its next bit once `en` is set again.
- R9: A request on the edge that retires the last bit of a frame is accepted. The new frame follows with no idle cycle between the two.
- R10: Asserting `rst` in the middle of a frame clears both registers and the counter, and the aborted frame does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Configuration enable for all tap operation |
| stub_vec | input | 127 | Stub vector from the coincidence logic, one bit per strip |
| stub_any | input | 1 | OR of all stubs this crossing; requests a capture |
| ser_data | output | 1 | Serial stub bit, low when not valid |
| ser_valid | output | 1 | Marks `ser_data` as a frame bit |
| ovf_count | output | 8 | Saturating count of dropped capture requests |

## Verification
Either shift register can hold a wrong internal state. If the shadow register does, the error shows as a frame whose valid length is not 127, or as a gap between back-to-back frames. The valid length can be measured one frame later, at most about 128 cycles after capture. If the data register holds a wrong state, the error shows as a wrong bit at a known position in the serial stream, seen in the cycle that bit is presented.

A mistake in busy detection shows at the ports in two ways: a dropped request that does not move `ovf_count` on the next cycle, or a frame replaced partway through. A freeze that leaks shows as a shifted frame or a moved counter once `en` returns.

// File: rtl/stub_tap_pkg.sv
package stub_tap_pkg;
  typedef enum logic [1:0] {
    TAP_HOLD  = 2'd0,
    TAP_LOAD  = 2'd1,
    TAP_SHIFT = 2'd2
  } tap_op_e;
endpackage

// File: rtl/stub_tap_ctrl.sv
module stub_tap_ctrl
  import stub_tap_pkg::*;
#(
  parameter int W = 127
) (
  input  logic         en,
  input  logic         stub_any,
  input  logic [W-1:0] shadow_q,
  output tap_op_e      op,
  output logic         drop
);
  // Bits still pending after the one presented now.
  logic more_after_head;
  logic any_pending;

  assign more_after_head = |shadow_q[W-1:1];
  assign any_pending     = |shadow_q;

  always_comb begin
    op   = TAP_HOLD;
    drop = 1'b0;
    if (en) begin
      if (stub_any && !more_after_head) begin
        op = TAP_LOAD;
      end else begin
        drop = stub_any;
        if (any_pending) op = TAP_SHIFT;
      end
    end
  end
endmodule

// File: rtl/stub_tap_data_sr.sv
module stub_tap_data_sr
  import stub_tap_pkg::*;
#(
  parameter int W = 127
) (
  input  logic         clk,
  input  logic         rst,
  input  tap_op_e      op,
  input  logic [W-1:0] load_val,
  output logic         head
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        TAP_LOAD:  q <= load_val;
        TAP_SHIFT: q <= {1'b0, q[W-1:1]};
        default:   q <= q;
      endcase
    end
  end

  assign head = q[0];
endmodule

// File: rtl/stub_tap_shadow_sr.sv
module stub_tap_shadow_sr
  import stub_tap_pkg::*;
#(
  parameter int W = 127
) (
  input  logic         clk,
  input  logic         rst,
  input  tap_op_e      op,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        TAP_LOAD:  q <= '1;
        TAP_SHIFT: q <= {1'b0, q[W-1:1]};
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/stub_tap_satcnt.sv
module stub_tap_satcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stub_serial_tap.sv
module stub_serial_tap
  import stub_tap_pkg::*;
#(
  parameter int STUB_W = 127,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [STUB_W-1:0] stub_vec,
  input  logic              stub_any,
  output logic              ser_data,
  output logic              ser_valid,
  output logic [CNT_W-1:0]  ovf_count
);
  tap_op_e           op;
  logic              drop;
  logic              data_head;
  logic [STUB_W-1:0] shadow_q;

  stub_tap_ctrl #(.W(STUB_W)) u_ctrl (
    .en       (en),
    .stub_any (stub_any),
    .shadow_q (shadow_q),
    .op       (op),
    .drop     (drop)
  );

  stub_tap_data_sr #(.W(STUB_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (stub_vec),
    .head     (data_head)
  );

  stub_tap_shadow_sr #(.W(STUB_W)) u_shadow (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .q   (shadow_q)
  );

  stub_tap_satcnt #(.CW(CNT_W)) u_ovf (
    .clk (clk),
    .rst (rst),
    .inc (drop),
    .cnt (ovf_count)
  );

  assign ser_valid = en & shadow_q[0];
  assign ser_data  = ser_valid & data_head;
endmodule

// File: rtl/stub_serial_tap_chk.sv
module stub_serial_tap_chk #(
  parameter int W  = 127,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          stub_any,
  input logic          ser_data,
  input logic          ser_valid,
  input logic [CW-1:0] ovf_count,
  input logic [W-1:0]  shadow_q
);
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !ser_valid |-> !ser_data);

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (en && stub_any && !(|shadow_q[W-1:1])) |=> (&shadow_q));

  assert_no_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!stub_any && shadow_q == '0) |=> (shadow_q == '0));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(shadow_q) && $stable(ovf_count)));

  assert_ovf_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_count == $past(ovf_count)) ||
              (ovf_count == $past(ovf_count) + 1'b1)));

  assert_ovf_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (&ovf_count) |=> (&ovf_count));
endmodule

bind stub_serial_tap stub_serial_tap_chk #(.W(STUB_W), .CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .stub_any  (stub_any),
  .ser_data  (ser_data),
  .ser_valid (ser_valid),
  .ovf_count (ovf_count),
  .shadow_q  (shadow_q)
);

// File: tb/stub_serial_tap_bench.sv
module stub_serial_tap_bench;
  localparam int W = 127;
  localparam int NPAT = 6;
  localparam logic [W-1:0] PAT [NPAT] = '{
    127'h1,
    127'h4000_0000_0000_0000_0000_0000_0000_0000,
    {W{1'b1}},
    127'h5555_5555_5555_5555_5555_5555_5555_5555,
    127'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    127'h7000_0000_0000_0F00_0000_0000_0000_800F
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b1;
  logic [W-1:0] stub_vec = '0;
  logic         stub_any = 1'b0;
  logic         ser_data, ser_valid;
  logic [7:0]   ovf_count;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;

  stub_serial_tap u_stub_serial_tap (
    .clk(clk), .rst(rst), .en(en), .stub_vec(stub_vec), .stub_any(stub_any),
    .ser_data(ser_data), .ser_valid(ser_valid), .ovf_count(ovf_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stub_any = 1'b0; stub_vec = '0; en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Load v on the next edge, then collect up to 140 cycles of stream.
  task automatic run_frame(input logic [W-1:0] v, output logic [W-1:0] got,
                           output int nv, output bit lowbad, output bit first_ok);
    @(negedge clk);
    stub_vec = v; stub_any = 1'b1;
    @(negedge clk);
    stub_vec = '0; stub_any = 1'b0;
    got = '0; nv = 0; lowbad = 1'b0;
    first_ok = ser_valid;
    for (int i = 0; i < 140; i++) begin
      if (ser_valid) begin
        if (nv < W) got[nv] = ser_data;
        nv++;
      end else if (ser_data) lowbad = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [W-1:0] got, got2;
    int nv, nv2;
    bit lowbad, first_ok, gap;

    do_reset();
    // R1: reset state
    chk(ser_valid == 1'b0 && ser_data == 1'b0, "R1 outputs after reset",
        {ser_valid, ser_data}, 0);
    chk(ovf_count == 8'd0, "R1 ovf after reset", ovf_count, 0);

    // Vector table: R2, R4, R5 per pattern
    for (int t = 0; t < NPAT; t++) begin
      run_frame(PAT[t], got, nv, lowbad, first_ok);
      chk(first_ok, "R2 valid after capture", first_ok, 1);
      chk(got == PAT[t], "R4 frame bits", got, PAT[t]);
      chk(nv == W, "R4 frame length", nv, W);
      chk(!lowbad, "R5 data low while not valid", lowbad, 0);
    end

    // R3: nonzero vector without the flag never captures
    gap = 1'b0;
    @(negedge clk);
    stub_vec = {W{1'b1}}; stub_any = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ser_valid || ser_data) gap = 1'b1;
    end
    chk(!gap, "R3 no capture without stub flag", gap, 0);
    stub_vec = '0;

    // R8 from idle: request while disabled is ignored and not counted
    en = 1'b0; stub_vec = PAT[4]; stub_any = 1'b1;
    repeat (4) @(negedge clk);
    stub_any = 1'b0; en = 1'b1;
    @(negedge clk);
    chk(ser_valid == 1'b0, "R8 no capture while disabled", ser_valid, 0);
    chk(ovf_count == 8'd0, "R8 no count while disabled", ovf_count, 0);

    // R6: requests during a frame are dropped and counted
    @(negedge clk);
    stub_vec = PAT[4]; stub_any = 1'b1;
    @(negedge clk);
    stub_any = 1'b0; got = '0; nv = 0;
    for (int i = 0; i < 140; i++) begin
      if (ser_valid) begin
        if (nv < W) got[nv] = ser_data;
        nv++;
      end
      if (i >= 10 && i <= 12) begin stub_any = 1'b1; stub_vec = PAT[2]; end
      else begin stub_any = 1'b0; stub_vec = '0; end
      @(negedge clk);
    end
    chk(got == PAT[4], "R6 frame intact after drops", got, PAT[4]);
    chk(nv == W, "R6 frame length after drops", nv, W);
    chk(ovf_count == 8'd3, "R6 drop count", ovf_count, 3);

    // R8: freeze mid-frame
    do_reset();
    @(negedge clk);
    stub_vec = PAT[5]; stub_any = 1'b1;
    @(negedge clk);
    stub_any = 1'b0; stub_vec = '0; got = '0; nv = 0; gap = 1'b0;
    for (int i = 0; i < 160; i++) begin
      if (!en && ser_valid) gap = 1'b1;
      if (ser_valid) begin
        if (nv < W) got[nv] = ser_data;
        nv++;
      end
      if (i >= 20 && i < 30) begin en = 1'b0; stub_any = 1'b1; stub_vec = PAT[2]; end
      else begin en = 1'b1; stub_any = 1'b0; stub_vec = '0; end
      @(negedge clk);
    end
    chk(!gap, "R8 valid low while disabled", gap, 0);
    chk(got == PAT[5], "R8 frame resumes intact", got, PAT[5]);
    chk(nv == W, "R8 frame length across freeze", nv, W);
    chk(ovf_count == 8'd0, "R8 counter frozen", ovf_count, 0);

    // R9: request in the last-bit cycle chains frames with no gap
    do_reset();
    @(negedge clk);
    stub_vec = PAT[3]; stub_any = 1'b1;
    @(negedge clk);
    stub_any = 1'b0; stub_vec = '0; gap = 1'b0; got = '0; got2 = '0;
    for (int i = 0; i < 2 * W; i++) begin
      if (!ser_valid) gap = 1'b1;
      if (i < W) got[i] = ser_data; else got2[i - W] = ser_data;
      if (i == W - 1) begin stub_any = 1'b1; stub_vec = PAT[4]; end
      else begin stub_any = 1'b0; stub_vec = '0; end
      @(negedge clk);
    end
    chk(!gap, "R9 no gap between frames", gap, 0);
    chk(got == PAT[3], "R9 first frame", got, PAT[3]);
    chk(got2 == PAT[4], "R9 chained frame", got2, PAT[4]);
    chk(ovf_count == 8'd0, "R9 chained request not counted", ovf_count, 0);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R9 idle after chained frame", ser_valid, 0);

    // R7: constant request saturates the counter
    do_reset();
    @(negedge clk);
    stub_vec = PAT[2]; stub_any = 1'b1;
    @(negedge clk);
    gap = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (!ser_valid) gap = 1'b1;
      @(negedge clk);
    end
    chk(ovf_count == 8'd255, "R7 counter saturates", ovf_count, 255);
    chk(!gap, "R9 continuous stream under constant request", gap, 0);

    // R10: reset mid-frame clears everything
    stub_any = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(ser_valid == 1'b0 && ovf_count == 8'd0, "R10 reset mid-frame",
        {ser_valid, ovf_count}, 0);
    gap = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ser_valid) gap = 1'b1;
    end
    chk(!gap, "R10 aborted frame does not resume", gap, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule